// File: doc/BRIEF.md
# Paired-Stream Bus Arbiter

This block decides which of several memory-copy streams owns a shared bus. Each stream pairs two channels, a destination end and a source end. A stream is requesting when either of its ends raises a request. A grant always goes to a whole stream, so both of its channel grants rise and fall together. With the default of two streams there are four channel request lines.

By default the order is fixed and the lower-numbered stream wins. A mode input switches to round-robin, where contested grants alternate between streams. A per-stream urgent flag lifts a requesting stream above every non-urgent one in either mode. When more than one stream is urgent, the mode rule breaks the tie. A stream keeps its grant for as long as it requests. The one exception is when the holder is not urgent and another requesting stream becomes urgent: the grant then moves to that stream.

Top module: `pds_arbiter`

## Requirements
- R1: While reset is asserted, and on the first clock after it is released, every grant output is 0, whatever the requests are.
- R2: Channel request and grant bit 2s is the destination end of stream s, and bit 2s+1 is its source end. Stream s requests when either bit is 1. A grant to stream s sets both bits 2s and 2s+1 of `ch_gnt` and bit s of `stream_gnt`. Grants are registered and appear on the clock edge after the requests that cause them.
- R3: At most one stream holds a grant in any cycle.
- R4: A grant goes only to a stream that was requesting at the previous edge. If any stream is requesting, some stream is granted after the next edge. When the holder stops requesting, its grant is gone after the next edge.
- R5: In fixed mode (`rr_mode`=0), when several candidates contend, the lowest-numbered stream wins. Stream 0 beats stream 1.
- R6: In round-robin mode (`rr_mode`=1), contention is settled by a pointer that starts at stream 0 after reset. Each new grant to stream w moves the pointer to stream w+1 (wrapping), so contested grants alternate.
- R7: When at least one requesting stream is urgent and no grant is being held, the new grant goes to an urgent stream, in either mode.
- R8: When several requesting streams are urgent, the mode rule of R5 or R6 picks among them.
- R9: A granted stream keeps its grant while it requests, unless R10 applies.
- R10: If the holder is not urgent and another requesting stream is urgent, the grant moves to that urgent stream at the next edge.
- R11: An urgent holder keeps its grant even when another urgent stream is requesting.
- R12: An urgent flag on a stream that is not requesting has no effect on any grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ch_req | input | 2*NUM_STREAMS | Channel requests; bit 2s is the destination end and bit 2s+1 the source end of stream s |
| rr_mode | input | 1 | 1 selects round-robin, 0 selects fixed order |
| stream_urgent | input | NUM_STREAMS | Urgent flag for each stream |
| ch_gnt | output | 2*NUM_STREAMS | Channel grants, same bit layout as ch_req |
| stream_gnt | output | NUM_STREAMS | One-hot stream grant (or all zeros) |

## Verification
The hardest case to reach is preemption: a non-urgent stream must already hold the grant when the other stream, which has been requesting all along, turns urgent. After that, the urgent flags must flip so that a new holder is, and then is not, shielded. The stimulus first establishes a fixed-mode grant to stream 0 while both streams request. It then raises urgency on stream 1 only, then on both, then on stream 0 only, holding the request lines steady throughout. Round-robin alternation is reached by releasing and re-raising a contested pair of requests several times, with a model of the pointer kept in step.

// File: rtl/pds_pkg.sv
package pds_pkg;

  localparam int MAX_STREAMS = 8;
  localparam int CH_PER_STREAM = 2;

  typedef logic [MAX_STREAMS-1:0] smask_t;

  function automatic logic bit_at(smask_t v, int k);
    return ((v >> k) & smask_t'(1)) != '0;
  endfunction

  function automatic smask_t one_at(int k);
    return smask_t'(1) << k;
  endfunction

  // lowest-numbered set bit among the first n
  function automatic smask_t lowest_first(smask_t v, int n);
    smask_t r;
    r = '0;
    for (int k = 0; k < MAX_STREAMS; k++) begin
      if (k < n && r == '0 && bit_at(v, k)) r = one_at(k);
    end
    return r;
  endfunction

  // first set bit found scanning upward from index p, wrapping at n
  function automatic smask_t from_pointer(smask_t v, int n, int p);
    smask_t r;
    int idx;
    r = '0;
    for (int k = 0; k < MAX_STREAMS; k++) begin
      idx = (p + k >= n) ? p + k - n : p + k;
      if (k < n && r == '0 && bit_at(v, idx)) r = one_at(idx);
    end
    return r;
  endfunction

  function automatic int mask_index(smask_t v);
    int r;
    r = 0;
    for (int k = MAX_STREAMS - 1; k >= 0; k--) begin
      if (bit_at(v, k)) r = k;
    end
    return r;
  endfunction

  function automatic int next_index(int i, int n);
    return (i + 1 >= n) ? 0 : i + 1;
  endfunction

endpackage

// File: rtl/pds_stream_req.sv
module pds_stream_req
  import pds_pkg::*;
#(
  parameter int NUM_STREAMS = 2,
  localparam int NUM_CH = NUM_STREAMS * CH_PER_STREAM
) (
  input  logic [NUM_CH-1:0]      ch_req,
  input  logic [NUM_STREAMS-1:0] stream_urgent,
  output logic [NUM_STREAMS-1:0] sreq,
  output logic [NUM_STREAMS-1:0] urg_req
);

  for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_stream
    // either end of the stream asks for the bus
    assign sreq[s]    = |ch_req[s*CH_PER_STREAM +: CH_PER_STREAM];
    // urgency counts only for a stream that actually requests
    assign urg_req[s] = stream_urgent[s] & sreq[s];
  end

endmodule

// File: rtl/pds_select.sv
module pds_select
  import pds_pkg::*;
#(
  parameter int NUM_STREAMS = 2,
  localparam int PTR_W = (NUM_STREAMS > 1) ? $clog2(NUM_STREAMS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_STREAMS-1:0] sreq,
  input  logic [NUM_STREAMS-1:0] urg_req,
  input  logic                   rr_mode,
  input  logic [PTR_W-1:0]       ptr_q,
  output logic [NUM_STREAMS-1:0] pick,
  output logic                   urgent_phase
);

  logic [NUM_STREAMS-1:0] cand;
  smask_t                 fixed_w;
  smask_t                 rr_w;

  // urgent requesters, when any exist, shadow all the others
  assign urgent_phase = |urg_req;
  assign cand         = urgent_phase ? urg_req : sreq;

  always_comb begin
    fixed_w = lowest_first(smask_t'(cand), NUM_STREAMS);
    rr_w    = from_pointer(smask_t'(cand), NUM_STREAMS, int'(ptr_q));
  end

  assign pick = rr_mode ? rr_w[NUM_STREAMS-1:0] : fixed_w[NUM_STREAMS-1:0];

  // R5: fixed order, stream 0 wins whenever it is a candidate
  assert_fixed_low_wins_R5 : assert property (@(posedge clk) disable iff (!rst_n)
    (!rr_mode && cand[0]) |-> pick[0]);

  // R8 / R7: the choice always lies inside the urgent set when one exists
  assert_pick_in_urgent_R8 : assert property (@(posedge clk) disable iff (!rst_n)
    urgent_phase |-> ((pick & ~urg_req) == '0));

  assert_pick_onehot_R3 : assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pick));

endmodule

// File: rtl/pds_grant_state.sv
module pds_grant_state
  import pds_pkg::*;
#(
  parameter int NUM_STREAMS = 2,
  localparam int PTR_W = (NUM_STREAMS > 1) ? $clog2(NUM_STREAMS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_STREAMS-1:0] sreq,
  input  logic [NUM_STREAMS-1:0] stream_urgent,
  input  logic [NUM_STREAMS-1:0] urg_req,
  input  logic [NUM_STREAMS-1:0] pick,
  output logic [NUM_STREAMS-1:0] holder_q,
  output logic [PTR_W-1:0]       ptr_q,
  output logic                   preempt
);

  logic holder_live;
  logic holder_urgent;
  logic keep;
  logic new_grant;
  logic [NUM_STREAMS-1:0] holder_d;
  logic [PTR_W-1:0]       ptr_d;

  assign holder_live   = |(holder_q & sreq);
  assign holder_urgent = |(holder_q & stream_urgent);
  // a non-urgent holder yields to any other urgent requester
  assign preempt       = holder_live && !holder_urgent && |(urg_req & ~holder_q);
  assign keep          = holder_live && !preempt;
  assign new_grant     = !keep && (|pick);

  assign holder_d = keep ? holder_q : pick;
  assign ptr_d    = new_grant
                  ? PTR_W'(next_index(mask_index(smask_t'(pick)), NUM_STREAMS))
                  : ptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      holder_q <= '0;
      ptr_q    <= '0;
    end else begin
      holder_q <= holder_d;
      ptr_q    <= ptr_d;
    end
  end

  assert_single_holder_R3 : assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(holder_q));

  assert_only_requesters_R4 : assert property (@(posedge clk) disable iff (!rst_n)
    (holder_q & ~$past(sreq)) == '0);

  assert_no_idle_R4 : assert property (@(posedge clk) disable iff (!rst_n)
    (|sreq) |=> (|holder_q));

  assert_hold_R9 : assert property (@(posedge clk) disable iff (!rst_n)
    (holder_live && !preempt) |=> (holder_q == $past(holder_q)));

  assert_preempt_moves_R10 : assert property (@(posedge clk) disable iff (!rst_n)
    preempt |=> (|(holder_q & $past(urg_req))));

  assert_urgent_first_R7 : assert property (@(posedge clk) disable iff (!rst_n)
    (!holder_live && (|urg_req)) |=> (|(holder_q & $past(urg_req))));

  assert_urgent_kept_R11 : assert property (@(posedge clk) disable iff (!rst_n)
    (holder_live && holder_urgent) |=> (holder_q == $past(holder_q)));

  assert_ptr_range_R6 : assert property (@(posedge clk) disable iff (!rst_n)
    int'(ptr_q) < NUM_STREAMS);

endmodule

// File: rtl/pds_arbiter.sv
module pds_arbiter
  import pds_pkg::*;
#(
  parameter int NUM_STREAMS = 2,
  localparam int NUM_CH = NUM_STREAMS * CH_PER_STREAM,
  localparam int PTR_W  = (NUM_STREAMS > 1) ? $clog2(NUM_STREAMS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_CH-1:0]      ch_req,
  input  logic                   rr_mode,
  input  logic [NUM_STREAMS-1:0] stream_urgent,
  output logic [NUM_CH-1:0]      ch_gnt,
  output logic [NUM_STREAMS-1:0] stream_gnt
);

  logic [NUM_STREAMS-1:0] sreq;
  logic [NUM_STREAMS-1:0] urg_req;
  logic [NUM_STREAMS-1:0] pick;
  logic [NUM_STREAMS-1:0] holder_q;
  logic [PTR_W-1:0]       ptr_q;
  logic                   urgent_phase;
  logic                   preempt;

  pds_stream_req #(.NUM_STREAMS(NUM_STREAMS)) u_req (
    .ch_req        (ch_req),
    .stream_urgent (stream_urgent),
    .sreq          (sreq),
    .urg_req       (urg_req)
  );

  pds_select #(.NUM_STREAMS(NUM_STREAMS)) u_sel (
    .clk          (clk),
    .rst_n        (rst_n),
    .sreq         (sreq),
    .urg_req      (urg_req),
    .rr_mode      (rr_mode),
    .ptr_q        (ptr_q),
    .pick         (pick),
    .urgent_phase (urgent_phase)
  );

  pds_grant_state #(.NUM_STREAMS(NUM_STREAMS)) u_state (
    .clk           (clk),
    .rst_n         (rst_n),
    .sreq          (sreq),
    .stream_urgent (stream_urgent),
    .urg_req       (urg_req),
    .pick          (pick),
    .holder_q      (holder_q),
    .ptr_q         (ptr_q),
    .preempt       (preempt)
  );

  assign stream_gnt = holder_q;

  // R2: both ends of the stream share one grant bit
  for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_fan
    assign ch_gnt[s*CH_PER_STREAM +: CH_PER_STREAM] = {CH_PER_STREAM{holder_q[s]}};
  end

  assert_preempt_needs_urgency_R12 : assert property (@(posedge clk) disable iff (!rst_n)
    preempt |-> urgent_phase);

endmodule

// File: tb/pds_arbiter_tb_top.sv
module pds_arbiter_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] req;
  logic       rr;
  logic [1:0] urg;
  wire  [3:0] gnt;
  wire  [1:0] sg;

  always #10 clk = ~clk;

  pds_arbiter #(.NUM_STREAMS(2)) dut_i (
    .clk (clk), .rst_n (rst_n), .ch_req (req), .rr_mode (rr),
    .stream_urgent (urg), .ch_gnt (gnt), .stream_gnt (sg)
  );

  logic [3:0] exp_q[$];
  string      tag_q[$];
  int checks = 0;
  int fails  = 0;
  int hold   = -1;
  int ptr    = 0;
  bit done   = 0;

  // driver: apply inputs, predict next grant from the requirements, enqueue
  task automatic step(input logic [3:0] r, input bit m, input logic [1:0] u, input string t);
    bit s0, s1, u0, u1, c0, c1, live;
    int win;
    @(negedge clk);
    req = r; rr = m; urg = u;
    s0 = r[0] | r[1];
    s1 = r[2] | r[3];
    u0 = u[0] & s0;
    u1 = u[1] & s1;
    live = (hold == 0 && s0) || (hold == 1 && s1);
    if (live && !(!u[hold] && (hold == 0 ? u1 : u0))) begin
      win = hold;
    end else begin
      if (u0 || u1) begin c0 = u0; c1 = u1; end
      else begin c0 = s0; c1 = s1; end
      if (c0 && c1) win = m ? ptr : 0;
      else if (c0) win = 0;
      else if (c1) win = 1;
      else win = -1;
      if (win >= 0) ptr = 1 - win;
    end
    hold = win;
    exp_q.push_back(win == 0 ? 4'b0011 : (win == 1 ? 4'b1100 : 4'b0000));
    tag_q.push_back(t);
  endtask

  // monitor: a quarter period after each edge, pop and compare
  logic [3:0] mon_e;
  string      mon_t;
  always @(posedge clk) begin
    #5;
    if (exp_q.size() != 0) begin
      mon_e = exp_q.pop_front();
      mon_t = tag_q.pop_front();
      checks++;
      if (gnt !== mon_e) begin
        fails++;
        $display("FAIL %s: ch_gnt=%b expected %b", mon_t, gnt, mon_e);
      end
      checks++;
      if (sg !== {mon_e[2], mon_e[0]}) begin
        fails++;
        $display("FAIL R2: stream_gnt=%b expected %b", sg, {mon_e[2], mon_e[0]});
      end
      checks++;  // R3: never two streams at once
      if (gnt[1:0] != 2'b00 && gnt[3:2] != 2'b00) begin
        fails++;
        $display("FAIL R3: ch_gnt=%b expected at most one stream", gnt);
      end
    end
  end

  initial begin
    rst_n = 1'b0; req = 4'b1111; rr = 1'b0; urg = 2'b11;
    repeat (3) @(posedge clk);
    #5;
    checks++;
    if (gnt !== 4'b0000 || sg !== 2'b00) begin
      fails++;
      $display("FAIL R1: ch_gnt=%b stream_gnt=%b expected 0000 00", gnt, sg);
    end
    @(negedge clk);
    req = 4'b0000; urg = 2'b00; rst_n = 1'b1;

    step(4'b0000, 0, 2'b00, "R1");
    step(4'b0001, 0, 2'b00, "R2");   // destination end alone
    step(4'b0000, 0, 2'b00, "R4");
    step(4'b1000, 0, 2'b00, "R2");   // source end alone
    step(4'b0100, 0, 2'b00, "R9");
    step(4'b0000, 0, 2'b00, "R4");
    step(4'b0101, 0, 2'b00, "R5");
    step(4'b0100, 0, 2'b00, "R4");   // holder drops, other takes over
    step(4'b0101, 0, 2'b00, "R9");
    step(4'b0000, 0, 2'b00, "R4");
    step(4'b1010, 0, 2'b00, "R5");
    step(4'b0000, 0, 2'b00, "R4");
    // round-robin alternation under repeated contention
    for (int i = 0; i < 4; i++) begin
      step(4'b1111, 1, 2'b00, "R6");
      step(4'b0000, 1, 2'b00, "R6");
    end
    // urgency from idle in both modes
    step(4'b0101, 0, 2'b10, "R7");
    step(4'b0000, 0, 2'b00, "R7");
    step(4'b0101, 1, 2'b10, "R7");
    step(4'b0000, 1, 2'b00, "R7");
    // both urgent: mode decides
    step(4'b0101, 0, 2'b11, "R8");
    step(4'b0000, 0, 2'b00, "R8");
    step(4'b0101, 1, 2'b11, "R8");
    step(4'b0000, 1, 2'b00, "R8");
    step(4'b0101, 1, 2'b11, "R8");
    step(4'b0000, 1, 2'b00, "R8");
    // preemption and its exception
    step(4'b0101, 0, 2'b00, "R9");
    step(4'b0101, 0, 2'b10, "R10");
    step(4'b0101, 0, 2'b11, "R11");
    step(4'b0101, 0, 2'b01, "R10");
    step(4'b0101, 0, 2'b11, "R11");
    step(4'b0000, 0, 2'b00, "R4");
    // urgency without request
    step(4'b0001, 0, 2'b10, "R12");
    step(4'b0001, 0, 2'b10, "R12");
    step(4'b0000, 1, 2'b01, "R12");
    step(4'b1000, 1, 2'b01, "R12");
    step(4'b0000, 0, 2'b00, "R4");
    repeat (3) @(posedge clk);
    #6;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule